// File: doc/BRIEF.md
# HDLC Bit-Stream Frame Receiver

This block turns a serial HDLC line into a stream of bytes for a receive queue. It hunts for the flag pattern 01111110 and opens a frame on it. It removes the zeros that the sender stuffed into the data and assembles the data into bytes. The last two bytes of each frame are the frame check sequence, which is checked and kept out of the queue. When a frame ends, one status byte is written after its data. A frame ends on a closing flag, on an abort pattern, or when the framer upstream reports loss of frame alignment. Alongside this, a detector watches the raw line for long runs of ones and raises an idle indication.

Bits are offered one at a time, qualified by a bit enable, so the block can run from a fast system clock. Every queue write carries a tag that separates data bytes from status bytes. The queue storage and any software access are kept outside the block.

Top module: `hdlc_frame_rx`

## Requirements
- R1: During reset and after it ends, no queue write is issued and `idleFlag` is low until line bits arrive.
- R2: The raw pattern 01111110 is a flag. The bytes between an opening and a closing flag are written with `wrIsStatus`=0, least significant bit first (the first bit received is bit 0). They are followed by one status byte with `wrIsStatus`=1. A clean frame gives status 0x08 (bit 3 = good end).
- R3: Inside a frame, a 0 that follows five consecutive 1s is deleted before bytes are assembled.
- R4: Two flags in a row, whether they share the middle 0 or not, produce no write. A single flag between two frames closes the first frame and opens the second.
- R5: A CRC-16 is run over the data and the check sequence: reflected polynomial 0x8408, start value 0xFFFF. A residue other than 0xF0B8 sets status bit 0. The last two complete bytes of a frame are never written as data.
- R6: A frame whose bit count between flags is not a multiple of 8 gets status bit 1.
- R7: A 0 followed by seven 1s inside a frame aborts it. The status byte has bit 2 set, and bits 1 and 0 are judged on the bits before the abort pattern. No status is written when the frame has delivered no bits, for example when ones follow a closing flag.
- R8: After an abort, line bits produce no writes until a flag is seen. That flag opens a new frame.
- R9: A high `alignLost` aborts a frame in progress, with status as in R7, judged over all payload bits except the last six received before the pulse. The payload bit offered in the same cycle is discarded, and a flag completing in that cycle is ignored.
- R10: `idleFlag` rises after the 15th consecutive received 1. It stays high while further 1s arrive and falls after the next 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Marks the cycle in which `bitIn` holds a new line bit |
| bitIn | input | 1 | Serial line bit |
| alignLost | input | 1 | Loss of frame alignment from the framer |
| wrEn | output | 1 | Queue write strobe, one cycle |
| wrData | output | 8 | Data byte or status byte |
| wrIsStatus | output | 1 | High when `wrData` is a status byte |
| idleFlag | output | 1 | Line idle (15 or more contiguous ones) |

## Verification
Loss of alignment and a byte completion can fall in the same cycle. This happens when the `alignLost` pulse arrives together with the payload bit whose entry would push a byte's eighth bit out of the lookahead. A directed frame pulses `alignLost` on payload bit 37, where the model expects the byte to be dropped, no further data write, and a status byte with the abort and bad-count bits set. Random frames also place the pulse at random payload positions, and a bound property checks that no data write ever follows an `alignLost` cycle.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic {
    HUNT = 1'b0,
    OPEN = 1'b1
  } rxState_e;

  // strobes from line control to the datapath
  typedef struct packed {
    logic push;    // payload bit enters the lookahead
    logic bitVal;  // value of that bit
    logic open;    // flag seen while hunting
    logic close;   // flag seen inside a frame
    logic abort;   // abort pattern or alignment loss inside a frame
  } rxStrobe_t;

  localparam int ST_BAD_CRC = 0;
  localparam int ST_BAD_CNT = 1;
  localparam int ST_ABORT   = 2;
  localparam int ST_GOOD    = 3;

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int IDLE_RUN = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       alignLost,
  output rxStrobe_t  strobes,
  output logic       idleFlag
);

  localparam int ONES_W = $clog2(IDLE_RUN + 1);
  localparam logic [ONES_W-1:0] STUFF_AT = ONES_W'(5);
  localparam logic [ONES_W-1:0] FLAG_AT  = ONES_W'(6);
  localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(IDLE_RUN);

  rxState_e          state, nextState;
  logic [ONES_W-1:0] onesCnt, nextOnes;
  rxStrobe_t         st;

  always_comb begin
    st        = '0;
    nextState = state;
    nextOnes  = onesCnt;
    if (bitEn) begin
      if (bitIn) begin
        if (onesCnt != RUN_MAX) nextOnes = onesCnt + 1'b1;
        if (state == OPEN && !alignLost) begin
          if (onesCnt < STUFF_AT) begin
            st.push   = 1'b1;
            st.bitVal = 1'b1;
          end else if (onesCnt == FLAG_AT) begin
            st.abort  = 1'b1;
            nextState = HUNT;
          end
        end
      end else begin
        nextOnes = '0;
        if (!alignLost) begin
          if (onesCnt == FLAG_AT) begin
            if (state == HUNT) begin
              st.open   = 1'b1;
              nextState = OPEN;
            end else begin
              st.close  = 1'b1;
            end
          end else if (onesCnt != STUFF_AT && state == OPEN) begin
            st.push   = 1'b1;
            st.bitVal = 1'b0;
          end
        end
      end
    end
    if (alignLost) begin
      st.abort  = (state == OPEN);
      nextState = HUNT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= HUNT;
      onesCnt <= '0;
    end else begin
      state   <= nextState;
      onesCnt <= nextOnes;
    end
  end

  assign strobes  = st;
  assign idleFlag = (onesCnt == RUN_MAX);

endmodule

// File: rtl/hdlc_rx_dp.sv
module hdlc_rx_dp
  import hdlc_rx_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobe_t  strobes,
  output logic       wrEn,
  output logic [7:0] wrData,
  output logic       wrIsStatus
);

  localparam int CRC_W     = 16;
  localparam int FCS_BYTES = CRC_W / 8;
  localparam int LAG       = 6;  // flag/abort lookahead in payload bits
  localparam int FILL_W    = $clog2(LAG + 1);
  localparam int HOLD_W    = $clog2(FCS_BYTES + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(LAG);
  localparam logic [HOLD_W-1:0] HOLD_FULL = HOLD_W'(FCS_BYTES);

  logic [LAG-1:0]    lookahead;
  logic [FILL_W-1:0] fill;
  logic [CRC_W-1:0]  crc, crcNext;
  logic [2:0]        bitPhase;
  logic              anyBit;
  logic [7:0]        byteSr, newByte;
  logic [7:0]        hold [FCS_BYTES];
  logic [HOLD_W-1:0] holdCnt;

  logic emerge, outBit, byteDone, frameReset, frameEnd;
  logic badCrc, badCnt;
  logic [7:0] statusByte;

  assign emerge     = strobes.push && (fill == FILL_FULL);
  assign outBit     = lookahead[LAG-1];
  assign crcNext    = {1'b0, crc[CRC_W-1:1]} ^ ((crc[0] ^ outBit) ? CRC_POLY : '0);
  assign newByte    = {outBit, byteSr[7:1]};
  assign byteDone   = emerge && (bitPhase == 3'd7);
  assign frameEnd   = strobes.close || strobes.abort;
  assign frameReset = frameEnd || strobes.open;
  assign badCrc     = (crc != CRC_GOOD);
  assign badCnt     = (bitPhase != 3'd0);

  always_comb begin
    statusByte              = '0;
    statusByte[ST_BAD_CRC]  = badCrc;
    statusByte[ST_BAD_CNT]  = badCnt;
    statusByte[ST_ABORT]    = strobes.abort;
    statusByte[ST_GOOD]     = strobes.close && !badCrc && !badCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lookahead  <= '0;
      fill       <= '0;
      crc        <= CRC_INIT;
      bitPhase   <= '0;
      anyBit     <= 1'b0;
      byteSr     <= '0;
      holdCnt    <= '0;
      wrEn       <= 1'b0;
      wrData     <= '0;
      wrIsStatus <= 1'b0;
      for (int i = 0; i < FCS_BYTES; i++) hold[i] <= '0;
    end else begin
      wrEn <= 1'b0;
      if (frameEnd && anyBit) begin
        wrEn       <= 1'b1;
        wrData     <= statusByte;
        wrIsStatus <= 1'b1;
      end
      if (frameReset) begin
        fill     <= '0;
        crc      <= CRC_INIT;
        bitPhase <= '0;
        anyBit   <= 1'b0;
        holdCnt  <= '0;
      end else if (strobes.push) begin
        lookahead <= {lookahead[LAG-2:0], strobes.bitVal};
        if (fill != FILL_FULL) fill <= fill + 1'b1;
        if (emerge) begin
          crc      <= crcNext;
          bitPhase <= bitPhase + 1'b1;
          anyBit   <= 1'b1;
          byteSr   <= newByte;
        end
        if (byteDone) begin
          if (holdCnt == HOLD_FULL) begin
            wrEn       <= 1'b1;
            wrData     <= hold[0];
            wrIsStatus <= 1'b0;
            for (int i = 0; i < FCS_BYTES - 1; i++) hold[i] <= hold[i+1];
            hold[FCS_BYTES-1] <= newByte;
          end else begin
            hold[holdCnt] <= newByte;
            holdCnt       <= holdCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx
  import hdlc_rx_pkg::*;
#(
  parameter int          IDLE_RUN = 15,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       alignLost,
  output logic       wrEn,
  output logic [7:0] wrData,
  output logic       wrIsStatus,
  output logic       idleFlag
);

  rxStrobe_t strobes;

  hdlc_rx_ctrl #(.IDLE_RUN(IDLE_RUN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .bitIn     (bitIn),
    .alignLost (alignLost),
    .strobes   (strobes),
    .idleFlag  (idleFlag)
  );

  hdlc_rx_dp #(
    .CRC_POLY (CRC_POLY),
    .CRC_INIT (CRC_INIT),
    .CRC_GOOD (CRC_GOOD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .wrIsStatus (wrIsStatus)
  );

endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk
  import hdlc_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       bitIn,
  input logic       alignLost,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       wrIsStatus,
  input logic       idleFlag,
  input rxStrobe_t  strobes
);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.push, strobes.open, strobes.close, strobes.abort}));

  // R2
  good_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIsStatus && wrData[3]) |-> (wrData[2:0] == 3'b000));

  // R7
  abort_not_good_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIsStatus) |-> !(wrData[2] && wrData[3]));

  // R7
  status_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIsStatus) |-> $past(strobes.close || strobes.abort));

  // R4
  open_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.open |=> !wrEn);

  // R9
  align_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignLost |=> !(wrEn && !wrIsStatus));

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !bitIn) |=> !idleFlag);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleFlag && bitEn && bitIn) |=> idleFlag);

endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitEn      (bitEn),
  .bitIn      (bitIn),
  .alignLost  (alignLost),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .wrIsStatus (wrIsStatus),
  .idleFlag   (idleFlag),
  .strobes    (strobes)
);

// File: tb/hdlc_frame_rx_tb.sv
module hdlc_frame_rx_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic bitIn = 1'b0;
  logic alignLost = 1'b0;
  logic wrEn, wrIsStatus, idleFlag;
  logic [7:0] wrData;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn), .alignLost(alignLost),
    .wrEn(wrEn), .wrData(wrData), .wrIsStatus(wrIsStatus), .idleFlag(idleFlag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic bitsArr [0:1023];
  int nBits;
  int onesRun;
  logic [8:0] expQ [$];
  string tagQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected write", int'({wrIsStatus, wrData}), 0);
      end else begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({wrIsStatus, wrData} == e, t, int'({wrIsStatus, wrData}), int'(e));
      end
    end
  end

  function automatic logic [15:0] crcOver(input int nb);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < nb; i++) begin
      logic fb;
      fb = c[0] ^ bitsArr[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic sendRaw(input logic b, input logic al);
    int gap;
    gap = int'($urandom_range(0, 2));
    repeat (gap) @(negedge clk);
    bitEn = 1'b1; bitIn = b; alignLost = al;
    @(negedge clk);
    bitEn = 1'b0; alignLost = 1'b0;
  endtask

  // payload bit with zero stuffing (R3)
  task automatic sendPayload(input logic b, input logic al);
    sendRaw(b, al);
    if (b) begin
      onesRun++;
      if (onesRun == 5) begin
        sendRaw(1'b0, 1'b0);
        onesRun = 0;
      end
    end else onesRun = 0;
  endtask

  task automatic sendFlag();
    sendRaw(1'b0, 1'b0);
    repeat (6) sendRaw(1'b1, 1'b0);
    sendRaw(1'b0, 1'b0);
    onesRun = 0;
  endtask

  task automatic sendOnes(input int n);
    repeat (n) sendRaw(1'b1, 1'b0);
  endtask

  task automatic pushExpect(input int m, input bit isAbort, input bit isAlign);
    int cb;
    bit crcBad, cntBad;
    logic [7:0] s;
    string stag;
    if (m <= 0) return;
    cb = m / 8;
    for (int j = 0; j < cb - 2; j++) begin
      logic [7:0] by;
      for (int k = 0; k < 8; k++) by[k] = bitsArr[j*8 + k];
      expQ.push_back({1'b0, by});
      tagQ.push_back(isAlign ? "R9 data byte" : "R2 data byte");
    end
    crcBad = (crcOver(m) != 16'hF0B8);
    cntBad = (m % 8) != 0;
    s = {5'd0, isAbort, cntBad, crcBad};
    if (!isAbort && !cntBad && !crcBad) s = 8'h08;
    if (isAlign) stag = "R9 status";
    else if (isAbort) stag = "R7 abort status";
    else if (cntBad) stag = "R6 bad count status";
    else if (crcBad) stag = "R5 bad crc status";
    else stag = "R2 good status";
    expQ.push_back({1'b1, s});
    tagQ.push_back(stag);
  endtask

  // kind: 0 good, 1 corrupt, 2 extra bits, 3 abort, 4 alignment loss
  task automatic runFrame(input int nBytes, input int kind, input int alignAtIn,
                          input int gapMode, input int fixedByte);
    logic [15:0] fcs;
    int alignAt;
    for (int j = 0; j < nBytes; j++) begin
      logic [7:0] by;
      if (fixedByte >= 0) by = 8'(fixedByte);
      else if ($urandom_range(0, 3) == 0) by = 8'hFF;
      else by = 8'($urandom);
      for (int k = 0; k < 8; k++) bitsArr[j*8 + k] = by[k];
    end
    fcs = ~crcOver(nBytes * 8);
    for (int k = 0; k < 16; k++) bitsArr[nBytes*8 + k] = fcs[k];
    nBits = nBytes * 8 + 16;
    if (kind == 1) bitsArr[3] = ~bitsArr[3];
    if (kind == 2) begin
      int extra;
      extra = int'($urandom_range(1, 7));
      for (int k = 0; k < extra; k++) bitsArr[nBits + k] = 1'($urandom);
      nBits += extra;
    end
    alignAt = -1;
    if (kind == 4) alignAt = (alignAtIn >= 0) ? alignAtIn : int'($urandom_range(7, nBits - 1));
    if (kind == 4) pushExpect(alignAt - 6, 1'b1, 1'b1);
    else pushExpect(nBits, kind == 3, 1'b0);
    onesRun = 0;
    for (int i = 0; i < nBits; i++) sendPayload(bitsArr[i], i == alignAt);
    if (kind == 3) begin
      sendRaw(1'b0, 1'b0);
      repeat (7) sendRaw(1'b1, 1'b0);
      onesRun = 0;
      repeat (int'($urandom_range(0, 3)) * 8) sendPayload(1'($urandom), 1'b0);  // R8 ignored bits
    end
    sendFlag();
    case (gapMode)
      1: sendFlag();
      2: begin repeat (6) sendRaw(1'b1, 1'b0); sendRaw(1'b0, 1'b0); end  // shared zero
      3: begin
        int n;
        n = int'($urandom_range(8, 20));
        sendOnes(n);
        if (n >= 15) check(idleFlag == 1'b1, "R10 idle during fill", int'(idleFlag), 1);
        sendFlag();
      end
      default: ;
    endcase
    @(negedge clk); #1;
    check(expQ.size() == 0, kind == 3 ? "R8 output after abort" : "R4 output after frame",
          expQ.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(wrEn == 1'b0, "R1 no write in reset", int'(wrEn), 0);
    check(idleFlag == 1'b0, "R1 idle low in reset", int'(idleFlag), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wrEn == 1'b0, "R1 no write after reset", int'(wrEn), 0);
    check(idleFlag == 1'b0, "R1 idle low after reset", int'(idleFlag), 0);

    // R10 idle threshold
    sendOnes(14);
    check(idleFlag == 1'b0, "R10 idle after 14 ones", int'(idleFlag), 0);
    sendRaw(1'b1, 1'b0);
    check(idleFlag == 1'b1, "R10 idle after 15 ones", int'(idleFlag), 1);
    sendRaw(1'b1, 1'b0);
    check(idleFlag == 1'b1, "R10 idle held on 16th one", int'(idleFlag), 1);
    sendRaw(1'b0, 1'b0);
    check(idleFlag == 1'b0, "R10 idle cleared by zero", int'(idleFlag), 0);

    // opening flag, then directed frames
    sendFlag();
    runFrame(3, 0, -1, 0, 8'h7E);   // R3 stuffing on flag-like data, single shared flag
    runFrame(3, 0, -1, 2, 8'hFF);   // R3 long ones, R4 flags sharing a zero
    runFrame(2, 1, -1, 1, -1);      // R5 bad crc
    runFrame(4, 2, -1, 3, -1);      // R6 extra bits, then ones fill
    runFrame(5, 3, -1, 0, -1);      // R7 abort, R8 ignored bits
    runFrame(6, 4, 37, 0, -1);      // R9 alignment loss on a byte completion
    runFrame(1, 0, -1, 1, -1);      // R2 shortest clean frame

    for (int f = 0; f < 40; f++) begin
      int r;
      int kind;
      r = int'($urandom_range(0, 9));
      kind = (r < 4) ? 0 : (r - 4 > 4 ? 4 : r - 4);
      runFrame(int'($urandom_range(1, 16)), kind, -1, int'($urandom_range(0, 3)), -1);
    end

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all expected writes seen", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule